// File: doc/BRIEF.md
# Cache Access Statistics Unit

This block sits beside a cache and consumes one outcome per access: whether the access hit, and whether it was a read or a write. It keeps four saturating counters, one each for read hits, write hits, read misses and write misses. From them it derives the total hits, the total misses, the number of stalled cycles and two integer percentages. Usage efficiency is the share of accesses that hit. Speed improvement is the cost without a cache divided by the cost with it. Both costs are weighted by a read penalty and a write penalty, which are captured while reset is asserted.

All derived values are published together, as one snapshot, after every counted access. A single shared restoring divider produces the two percentages, one quotient bit per clock. While a recomputation runs, `stats_valid_o` is low. When the new snapshot lands, `stats_done_o` pulses for one cycle and `stats_valid_o` rises. An access that arrives during a recomputation waits in a one-entry buffer.

The controller has five states:
- ST_IDLE: waiting.
- ST_CALC: derived sums are formed and the efficiency division is started.
- ST_EFF: waiting for the efficiency quotient.
- ST_SPD: waiting for the speed quotient.
- ST_PUB: the snapshot is registered.

The transitions are:
- ST_IDLE→ST_CALC when a buffered or incoming access is counted.
- ST_CALC→ST_EFF when the access total is non-zero.
- ST_CALC→ST_PUB when the access total is zero.
- ST_EFF→ST_SPD on divider completion.
- ST_SPD→ST_PUB on divider completion.
- ST_PUB→ST_IDLE always.

Reset enters ST_CALC, so the zero-access defaults are republished.

Top module: `cache_stats_unit`

## Requirements
- R1: Each counted access increments exactly one counter, selected by its flags: hit with read is a read hit, hit with write is a write hit, miss with read is a read miss, miss with write is a write miss. The published counters `rd_hit_o`, `wr_hit_o`, `rd_miss_o` and `wr_miss_o` show the result.
- R2: `hits_total_o` equals read hits plus write hits, and `misses_total_o` equals read misses plus write misses.
- R3: `stall_o` equals read misses × (read penalty − 1) plus write misses × (write penalty − 1).
- R4: `eff_pct_o` is floor(total hits × 100 / total accesses). It is 0 when there have been no accesses.
- R5: `speed_pct_o` is floor(uncached cost × 100 / cached cost). The uncached cost is (read hits + read misses) × read penalty plus (write hits + write misses) × write penalty. The cached cost is total hits plus read misses × read penalty plus write misses × write penalty. The result is 100 when there have been no accesses.
- R6: Reset clears all counters and holds `stats_valid_o` low. After release, a snapshot with zero counts, efficiency 0 and speed 100 is published.
- R7: `stats_valid_o` is low from the clock edge that counts an access until the new snapshot is published. `stats_done_o` is high for exactly the one cycle in which the snapshot first appears. Published values do not change while `stats_valid_o` stays high.
- R8: An access presented while a recomputation is running is held in a one-entry buffer and counted afterwards. Further accesses presented while that buffer is full are dropped.
- R9: Counters saturate at 2^CNT_W − 1 and never wrap.
- R10: The penalty inputs are sampled only while reset is asserted. Changing them afterwards has no effect on any result. Both penalties must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; penalties are sampled while low |
| rd_pen_i | input | PEN_W | Read miss penalty in cycles (≥ 1) |
| wr_pen_i | input | PEN_W | Write miss penalty in cycles (≥ 1) |
| acc_valid_i | input | 1 | An access outcome is presented this cycle |
| acc_hit_i | input | 1 | 1 = hit, 0 = miss |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| stats_valid_o | output | 1 | Published snapshot is current |
| stats_done_o | output | 1 | One-cycle pulse when a snapshot is published |
| rd_hit_o | output | CNT_W | Published read-hit count |
| wr_hit_o | output | CNT_W | Published write-hit count |
| rd_miss_o | output | CNT_W | Published read-miss count |
| wr_miss_o | output | CNT_W | Published write-miss count |
| hits_total_o | output | CNT_W+1 | Total hits |
| misses_total_o | output | CNT_W+1 | Total misses |
| stall_o | output | CNT_W+PEN_W+1 | Stalled cycles |
| eff_pct_o | output | PCT_W | Usage efficiency, integer percent |
| speed_pct_o | output | PCT_W | Speed improvement, integer percent |

## Verification
The bench drives the zero-access state both after power-up and after a reset in mid-run. A design that did not republish after reset would leave stale totals visible, and one that divided by zero would report garbage instead of 0 and 100. It drives three back-to-back accesses into a running recomputation; a design without the buffer would lose the second one, and one without the full check would count the third. It changes the penalty inputs after reset, which catches a design that reads them live and so gives wrong stall and speed figures. It also saturates a narrow build's counter, which catches a counter that wraps back to a small value.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_EFF,
        ST_SPD,
        ST_PUB
    } cs_state_e;

    localparam int PCT_SCALE = 100;

    // counter slot encoding: {miss, write}
    localparam int SLOT_RD_HIT  = 0;
    localparam int SLOT_WR_HIT  = 1;
    localparam int SLOT_RD_MISS = 2;
    localparam int SLOT_WR_MISS = 3;
    localparam int N_SLOTS      = 4;
endpackage

// File: rtl/cs_counters.sv
module cs_counters
    import cs_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc_i,
    input  logic                          hit_i,
    input  logic                          write_i,
    output logic [N_SLOTS-1:0][CNT_W-1:0] cnt_o
);
    logic [1:0] slot;
    assign slot = {~hit_i, write_i};

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_o[g] <= '0;
            end else if (inc_i && (slot == 2'(g)) && (cnt_o[g] != {CNT_W{1'b1}})) begin
                cnt_o[g] <= cnt_o[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cs_divider.sv
module cs_divider #(
    parameter int DW = 64,
    parameter int QW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic          done_o,
    output logic [QW-1:0] quo_o
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] rem_q;
    logic [DW-1:0] quo_q;
    logic [DW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [DW:0]   shifted;
    logic          fits;

    assign shifted = {rem_q, quo_q[DW-1]};
    assign fits    = shifted >= {1'b0, dvs_q};
    assign quo_o   = quo_q[QW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q  <= '0;
                quo_q  <= dividend_i;
                dvs_q  <= divisor_i;
                cnt_q  <= CW'(DW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= DW'(shifted - {1'b0, dvs_q});
                    quo_q <= {quo_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[DW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cache_stats_unit.sv
module cache_stats_unit
    import cs_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PEN_W = 16,
    parameter int PCT_W = 32,
    parameter int DIV_W = 64,
    localparam int TOT_W   = CNT_W + 1,
    localparam int STALL_W = CNT_W + PEN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PEN_W-1:0]   rd_pen_i,
    input  logic [PEN_W-1:0]   wr_pen_i,
    input  logic               acc_valid_i,
    input  logic               acc_hit_i,
    input  logic               acc_write_i,
    output logic               stats_valid_o,
    output logic               stats_done_o,
    output logic [CNT_W-1:0]   rd_hit_o,
    output logic [CNT_W-1:0]   wr_hit_o,
    output logic [CNT_W-1:0]   rd_miss_o,
    output logic [CNT_W-1:0]   wr_miss_o,
    output logic [TOT_W-1:0]   hits_total_o,
    output logic [TOT_W-1:0]   misses_total_o,
    output logic [STALL_W-1:0] stall_o,
    output logic [PCT_W-1:0]   eff_pct_o,
    output logic [PCT_W-1:0]   speed_pct_o
);
    cs_state_e state_q, state_n;

    logic [PEN_W-1:0] rp_q, wp_q;
    logic             buf_full_q, buf_hit_q, buf_wr_q;
    logic             inc, sel_hit, sel_wr;
    logic [N_SLOTS-1:0][CNT_W-1:0] cnt;
    logic [PCT_W-1:0] eff_q, spd_q;

    logic [DIV_W-1:0] w_rh, w_wh, w_rm, w_wm, w_rp, w_wp;
    logic [DIV_W-1:0] tot_hit, tot_miss, tot_acc, stall_c;
    logic [DIV_W-1:0] uncached, cached, eff_num, spd_num;
    logic             div_start, div_done;
    logic [DIV_W-1:0] div_dvd, div_dvs;
    logic [PCT_W-1:0] div_quo;

    // access selection: buffered entry takes precedence
    assign inc     = (state_q == ST_IDLE) && (buf_full_q || acc_valid_i);
    assign sel_hit = buf_full_q ? buf_hit_q : acc_hit_i;
    assign sel_wr  = buf_full_q ? buf_wr_q  : acc_write_i;

    cs_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc),
        .hit_i   (sel_hit),
        .write_i (sel_wr),
        .cnt_o   (cnt)
    );

    // derived sums, all widened to the divider width
    assign w_rh     = DIV_W'(cnt[SLOT_RD_HIT]);
    assign w_wh     = DIV_W'(cnt[SLOT_WR_HIT]);
    assign w_rm     = DIV_W'(cnt[SLOT_RD_MISS]);
    assign w_wm     = DIV_W'(cnt[SLOT_WR_MISS]);
    assign w_rp     = DIV_W'(rp_q);
    assign w_wp     = DIV_W'(wp_q);
    assign tot_hit  = w_rh + w_wh;
    assign tot_miss = w_rm + w_wm;
    assign tot_acc  = tot_hit + tot_miss;
    assign stall_c  = w_rm * (w_rp - 1'b1) + w_wm * (w_wp - 1'b1);
    assign uncached = (w_rh + w_rm) * w_rp + (w_wh + w_wm) * w_wp;
    assign cached   = tot_hit + w_rm * w_rp + w_wm * w_wp;
    assign eff_num  = tot_hit * DIV_W'(PCT_SCALE);
    assign spd_num  = uncached * DIV_W'(PCT_SCALE);

    // one shared divider: efficiency first, then speed
    assign div_start = ((state_q == ST_CALC) && (tot_acc != '0)) ||
                       ((state_q == ST_EFF) && div_done);
    assign div_dvd   = (state_q == ST_CALC) ? eff_num : spd_num;
    assign div_dvs   = (state_q == ST_CALC) ? tot_acc : cached;

    cs_divider #(.DW(DIV_W), .QW(PCT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .done_o     (div_done),
        .quo_o      (div_quo)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (inc) state_n = ST_CALC;
            ST_CALC: state_n = (tot_acc != '0) ? ST_EFF : ST_PUB;
            ST_EFF:  if (div_done) state_n = ST_SPD;
            ST_SPD:  if (div_done) state_n = ST_PUB;
            ST_PUB:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CALC;
        else        state_q <= state_n;
    end

    // outputs, buffer and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q           <= rd_pen_i;
            wp_q           <= wr_pen_i;
            buf_full_q     <= 1'b0;
            buf_hit_q      <= 1'b0;
            buf_wr_q       <= 1'b0;
            eff_q          <= '0;
            spd_q          <= '0;
            stats_valid_o  <= 1'b0;
            stats_done_o   <= 1'b0;
            rd_hit_o       <= '0;
            wr_hit_o       <= '0;
            rd_miss_o      <= '0;
            wr_miss_o      <= '0;
            hits_total_o   <= '0;
            misses_total_o <= '0;
            stall_o        <= '0;
            eff_pct_o      <= '0;
            speed_pct_o    <= '0;
        end else begin
            stats_done_o  <= 1'b0;
            stats_valid_o <= (state_n == ST_IDLE);

            if (state_q == ST_IDLE) begin
                // buffer drains this cycle; refill only if it was the one consumed
                if (buf_full_q) begin
                    buf_full_q <= acc_valid_i;
                    buf_hit_q  <= acc_hit_i;
                    buf_wr_q   <= acc_write_i;
                end
            end else if (acc_valid_i && !buf_full_q) begin
                buf_full_q <= 1'b1;
                buf_hit_q  <= acc_hit_i;
                buf_wr_q   <= acc_write_i;
            end

            unique case (state_q)
                ST_CALC: begin
                    if (tot_acc == '0) begin
                        eff_q <= '0;
                        spd_q <= PCT_W'(PCT_SCALE);
                    end
                end
                ST_EFF: if (div_done) eff_q <= div_quo;
                ST_SPD: if (div_done) spd_q <= div_quo;
                ST_PUB: begin
                    stats_done_o   <= 1'b1;
                    rd_hit_o       <= cnt[SLOT_RD_HIT];
                    wr_hit_o       <= cnt[SLOT_WR_HIT];
                    rd_miss_o      <= cnt[SLOT_RD_MISS];
                    wr_miss_o      <= cnt[SLOT_WR_MISS];
                    hits_total_o   <= TOT_W'(tot_hit);
                    misses_total_o <= TOT_W'(tot_miss);
                    stall_o        <= STALL_W'(stall_c);
                    eff_pct_o      <= eff_q;
                    speed_pct_o    <= spd_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int CNT_W = 32,
    parameter int PCT_W = 32,
    localparam int TOT_W = CNT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stats_valid_o,
    input logic             stats_done_o,
    input logic [CNT_W-1:0] rd_hit_o,
    input logic [CNT_W-1:0] wr_hit_o,
    input logic [CNT_W-1:0] rd_miss_o,
    input logic [CNT_W-1:0] wr_miss_o,
    input logic [TOT_W-1:0] hits_total_o,
    input logic [TOT_W-1:0] misses_total_o,
    input logic [PCT_W-1:0] eff_pct_o,
    input logic [PCT_W-1:0] speed_pct_o
);
    logic [CNT_W-1:0] prev_rh, prev_wh, prev_rm, prev_wm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rh <= '0; prev_wh <= '0; prev_rm <= '0; prev_wm <= '0;
        end else if (stats_done_o) begin
            prev_rh <= rd_hit_o; prev_wh <= wr_hit_o;
            prev_rm <= rd_miss_o; prev_wm <= wr_miss_o;
        end
    end

    p_totals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stats_valid_o |-> (hits_total_o == TOT_W'(rd_hit_o) + TOT_W'(wr_hit_o)) &&
                          (misses_total_o == TOT_W'(rd_miss_o) + TOT_W'(wr_miss_o)));

    p_eff_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stats_valid_o |-> eff_pct_o <= PCT_W'(100));

    p_zero_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stats_valid_o && hits_total_o == '0 && misses_total_o == '0)
            |-> (speed_pct_o == PCT_W'(100)) && (eff_pct_o == '0));

    p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stats_done_o |-> stats_valid_o);

    p_rise_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stats_valid_o) |-> stats_done_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stats_valid_o && !stats_done_o) |-> $stable(eff_pct_o) && $stable(speed_pct_o));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stats_done_o |-> (rd_hit_o >= prev_rh) && (wr_hit_o >= prev_wh) &&
                         (rd_miss_o >= prev_rm) && (wr_miss_o >= prev_wm));
endmodule

bind cache_stats_unit cs_checker #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stats_valid_o  (stats_valid_o),
    .stats_done_o   (stats_done_o),
    .rd_hit_o       (rd_hit_o),
    .wr_hit_o       (wr_hit_o),
    .rd_miss_o      (rd_miss_o),
    .wr_miss_o      (wr_miss_o),
    .hits_total_o   (hits_total_o),
    .misses_total_o (misses_total_o),
    .eff_pct_o      (eff_pct_o),
    .speed_pct_o    (speed_pct_o)
);

// File: tb/cache_stats_unit_tb.sv
module cache_stats_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {hit, write} per access
    localparam logic [1:0] VEC [NVEC] = '{2'b10, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10,
                                          2'b00, 2'b11, 2'b11, 2'b01, 2'b10, 2'b00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] rd_pen = 16'd10, wr_pen = 16'd20;
    logic acc_valid = 1'b0, acc_hit = 1'b0, acc_write = 1'b0;
    logic stats_valid, stats_done;
    logic [31:0] rh, wh, rm, wm, eff, spd;
    logic [32:0] htot, mtot;
    logic [48:0] stall;

    logic s_valid = 1'b0;
    logic s_sv, s_sd;
    logic [2:0] s_rh, s_wh, s_rm, s_wm;
    logic [3:0] s_ht, s_mt;
    logic [19:0] s_stall;
    logic [31:0] s_eff, s_spd;

    int checks = 0, failures = 0;
    longint mrh = 0, mwh = 0, mrm = 0, mwm = 0, mrp = 10, mwp = 20;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_stats_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rd_pen_i(rd_pen), .wr_pen_i(wr_pen),
        .acc_valid_i(acc_valid), .acc_hit_i(acc_hit), .acc_write_i(acc_write),
        .stats_valid_o(stats_valid), .stats_done_o(stats_done),
        .rd_hit_o(rh), .wr_hit_o(wh), .rd_miss_o(rm), .wr_miss_o(wm),
        .hits_total_o(htot), .misses_total_o(mtot), .stall_o(stall),
        .eff_pct_o(eff), .speed_pct_o(spd));

    cache_stats_unit #(.CNT_W(3)) u_sat (
        .clk(clk), .rst_n(rst_n), .rd_pen_i(16'd10), .wr_pen_i(16'd20),
        .acc_valid_i(s_valid), .acc_hit_i(1'b1), .acc_write_i(1'b0),
        .stats_valid_o(s_sv), .stats_done_o(s_sd),
        .rd_hit_o(s_rh), .wr_hit_o(s_wh), .rd_miss_o(s_rm), .wr_miss_o(s_wm),
        .hits_total_o(s_ht), .misses_total_o(s_mt), .stall_o(s_stall),
        .eff_pct_o(s_eff), .speed_pct_o(s_spd));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic model_add(input logic h, input logic w);
        case ({h, w})
            2'b10: mrh++;
            2'b11: mwh++;
            2'b00: mrm++;
            default: mwm++;
        endcase
    endtask

    task automatic check_all(input string tag);
        longint acc, ee, se;
        acc = mrh + mwh + mrm + mwm;
        ee  = (acc == 0) ? 0 : ((mrh + mwh) * 100) / acc;
        se  = (acc == 0) ? 100 :
              (((mrh + mrm) * mrp + (mwh + mwm) * mwp) * 100) / (mrh + mwh + mrm * mrp + mwm * mwp);
        chk_eq({"R1 rd_hit ", tag}, longint'(rh), mrh);
        chk_eq({"R1 wr_hit ", tag}, longint'(wh), mwh);
        chk_eq({"R1 rd_miss ", tag}, longint'(rm), mrm);
        chk_eq({"R1 wr_miss ", tag}, longint'(wm), mwm);
        chk_eq({"R2 hits ", tag}, longint'(htot), mrh + mwh);
        chk_eq({"R2 misses ", tag}, longint'(mtot), mrm + mwm);
        chk_eq({"R3 stall ", tag}, longint'(stall), mrm * (mrp - 1) + mwm * (mwp - 1));
        chk_eq({"R4 eff ", tag}, longint'(eff), ee);
        chk_eq({"R5 speed ", tag}, longint'(spd), se);
    endtask

    task automatic send(input logic h, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = h; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!stats_done && n < 2000);
        chk(stats_done == 1'b1, {req, " done timeout"}, longint'(stats_done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk_eq("R6 valid low in reset", longint'(stats_valid), 0);
        rst_n = 1'b1;
        wait_done("R6");
        check_all("after reset");
        chk_eq("R6 default eff", longint'(eff), 0);
        chk_eq("R6 default speed", longint'(spd), 100);

        // table walk: R1..R5, R7
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][1], VEC[i][0]);
            chk_eq("R7 valid low while busy", longint'(stats_valid), 0);
            model_add(VEC[i][1], VEC[i][0]);
            wait_done("R7");
            check_all($sformatf("vec%0d", i));
            @(negedge clk);
            chk_eq("R7 done is one cycle", longint'(stats_done), 0);
            chk_eq("R7 valid held", longint'(stats_valid), 1);
        end

        // R10: penalty change after reset is ignored
        rd_pen = 16'd3; wr_pen = 16'd2;
        send(1'b0, 1'b0);
        model_add(1'b0, 1'b0);
        wait_done("R10");
        check_all("R10 old penalties");

        // R8: back-to-back accesses, third dropped
        @(negedge clk); acc_valid = 1'b1; acc_hit = 1'b0; acc_write = 1'b0;
        @(negedge clk); acc_hit = 1'b1; acc_write = 1'b1;
        @(negedge clk); acc_hit = 1'b0; acc_write = 1'b1;
        @(negedge clk); acc_valid = 1'b0;
        model_add(1'b0, 1'b0);
        wait_done("R8 first");
        check_all("R8 first");
        model_add(1'b1, 1'b1);
        wait_done("R8 buffered");
        check_all("R8 buffered");
        begin
            bit extra = 1'b0;
            repeat (300) begin
                @(negedge clk);
                if (stats_done) extra = 1'b1;
            end
            chk_eq("R8 no update for dropped access", longint'(extra), 0);
            check_all("R8 dropped");
        end

        // R6/R10: mid-run reset with new penalties
        rd_pen = 16'd4; wr_pen = 16'd7;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R6 valid low in mid reset", longint'(stats_valid), 0);
        rst_n = 1'b1;
        mrh = 0; mwh = 0; mrm = 0; mwm = 0; mrp = 4; mwp = 7;
        wait_done("R6 mid");
        check_all("R6 cleared");
        send(1'b0, 1'b1);
        model_add(1'b0, 1'b1);
        wait_done("R10 resampled");
        check_all("R10 resampled");

        // R9: saturation in a 3-bit build
        for (int k = 0; k < 9; k++) begin
            @(negedge clk); s_valid = 1'b1;
            @(negedge clk); s_valid = 1'b0;
            begin
                int n = 0;
                do begin @(negedge clk); n++; end while (!s_sd && n < 2000);
            end
        end
        chk_eq("R9 saturated rd_hit", longint'(s_rh), 7);
        chk_eq("R9 saturated total", longint'(s_ht), 7);
        chk_eq("R9 eff at saturation", longint'(s_eff), 100);
        chk_eq("R9 speed at saturation", longint'(s_spd), 1000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule